// File: doc/BRIEF.md
# Configurable Memory-Mapped GPIO Controller

This block gives a processor register access to a bank of general-purpose I/O lines over a simple single-cycle bus. There is one word address for each of four registers. A write takes effect on the clock edge where it is sampled. A read returns its word on the clock edge where the read enable is sampled, and the read data holds that word until the next read.

Each line has an output value and an output enable, and these go to pad logic outside the block. The level of each line comes back on a pin vector, which passes through a two-flop synchronizer before any register sees it.

The output value can be changed in three ways: by loading a whole word, by writing ones to set lines, or by writing ones to clear lines. The clear register can be removed by a parameter. Without it, a write to the set register loads the whole output word. Other parameters choose the register width, the polarity of the direction register and whether line numbering is mirrored across the word.

Register addresses are fixed. Address 0 is the level register: a read gives the synchronized line levels and a write loads the whole output value. Address 1 is the set register. Address 2 is the clear register. Address 3 is the direction register.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every line output value is 0, every line is an input (output enable 0) and the read data is 0.
- R2: With the clear register present, writing to address 1 sets every line whose bit is 1. Lines whose bit is 0 keep their output value.
- R3: With the clear register present, writing to address 2 drives every line whose bit is 1 low. Lines whose bit is 0 keep their value. A read of address 2 returns 0.
- R4: With the clear register absent, writing to address 1 loads the whole output word, so 0 bits drive their lines low. A write to address 2 changes no line.
- R5: Writing to address 0 loads the whole output value word.
- R6: Address 3 holds the direction bits, and a read of it returns what was written. In output-select polarity a 1 makes the line an output and the reset value is all zeros. In input-select polarity a 1 makes the line an input and the reset value is all ones.
- R7: A read of address 0 returns the pin level of each line through a two-flop synchronizer. A pin level that is stable before two rising edges is returned by a read sampled on the third edge. A read sampled on the first edge still returns the previous level.
- R8: A read of address 1 returns, for each line, the driven output value if the line is an output and the synchronized pin level if it is an input.
- R9: With mirrored numbering, line n sits at bit WIDTH-1-n of every register, for both writes and reads.
- R10: The read data changes only on an edge where the read enable is sampled high. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 level, 1 set, 2 clear, 3 direction |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | WIDTH | Write data in register bit order |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Asynchronous line levels, indexed by line |
| line_out | output | WIDTH | Driven output value per line |
| line_oe | output | WIDTH | Output enable per line |

## Verification
A corrupted output-value or direction register shows on line_out or line_oe on the edge right after the write that caused it. Nothing has to be read back to see it. A wrong synchronizer depth or a wrong read mux shows on bus_rd_data one edge after the read strobe, and a read issued too early gives away an extra or a missing stage. Mirroring faults show as a line moved to the far end of the word, both on the line outputs and in the read data.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO controller: register addresses.
package gpio_pkg;
    typedef enum logic [1:0] {
        REG_LEVEL = 2'd0,
        REG_SET   = 2'd1,
        REG_CLR   = 2'd2,
        REG_DIR   = 2'd3
    } gpio_reg_e;
endpackage

// File: rtl/gpio_bitmap.sv
// Maps between register bit order and line order.
// Assumes: the mapping is its own inverse, so the same module serves
// both the write path and the read path.
module gpio_bitmap #(
    parameter int WIDTH  = 32,
    parameter bit MIRROR = 1'b0
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (MIRROR) begin : g_mir
            assign dout[i] = din[WIDTH-1-i];
        end else begin : g_str
            assign dout[i] = din[i];
        end
    end
endmodule

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for the line level vector.
// Assumes: each line is independent, so no multi-bit coherency is needed.
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;

    // shift the pin levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_out <= '0;
        end else begin
            stage1_q <= async_in;
            sync_out <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_out_reg.sv
// Output value register with whole-word load, write-one-to-set and
// write-one-to-clear.
// Assumes: at most one of the write strobes is high in a cycle. With
// HAS_CLR = 0 the set strobe loads the whole word and the clear strobe
// is ignored.
module gpio_out_reg #(
    parameter int WIDTH   = 32,
    parameter bit HAS_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_load,
    input  logic             we_set,
    input  logic             we_clr,
    input  logic [WIDTH-1:0] wline,
    output logic [WIDTH-1:0] q
);
    // update the driven value from whichever strobe is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we_load) begin
            q <= wline;
        end else if (we_set) begin
            q <= HAS_CLR ? (q | wline) : wline;
        end else if (we_clr && HAS_CLR) begin
            q <= q & ~wline;
        end
    end

    a_r2_set_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (we_set && HAS_CLR) |=> (((q & $past(wline)) == $past(wline)) &&
                                 ((q & ~$past(wline)) == ($past(q) & ~$past(wline)))));

    a_r3_clr_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (we_clr && HAS_CLR) |=> (((q & $past(wline)) == '0) &&
                                 ((q & ~$past(wline)) == ($past(q) & ~$past(wline)))));

    a_r4_set_loads_word: assert property (@(posedge clk) disable iff (!rst_n)
        (we_set && !HAS_CLR) |=> (q == $past(wline)));

    a_r5_level_loads_word: assert property (@(posedge clk) disable iff (!rst_n)
        we_load |=> (q == $past(wline)));
endmodule

// File: rtl/gpio_dir_reg.sv
// Direction register with selectable polarity.
// Assumes: the reset value leaves every line as an input under either
// polarity.
module gpio_dir_reg #(
    parameter int WIDTH        = 32,
    parameter bit DIR_IS_INPUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wline,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] oe
);
    localparam logic [WIDTH-1:0] RST_VAL = DIR_IS_INPUT ? '1 : '0;

    // hold the direction bits as written
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else if (we) q <= wline;
    end

    // convert direction bits to output enables
    always_comb oe = DIR_IS_INPUT ? ~q : q;

    a_r6_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/mmio_gpio_ctrl.sv
// Memory-mapped GPIO controller top: address decode, output value,
// direction, pin synchronizer and registered read mux.
// Assumes: WIDTH is 8, 16, 32 or 64; one register access per cycle.
module mmio_gpio_ctrl #(
    parameter int WIDTH        = 32,
    parameter bit HAS_CLR      = 1'b1,
    parameter bit DIR_IS_INPUT = 1'b0,
    parameter bit MIRROR       = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr_en,
    input  logic [WIDTH-1:0] bus_wr_data,
    input  logic             bus_rd_en,
    output logic [WIDTH-1:0] bus_rd_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] line_out,
    output logic [WIDTH-1:0] line_oe
);
    import gpio_pkg::*;

    logic [WIDTH-1:0] wline, pin_s, dir_q, rd_line, rd_bus;
    logic we_load, we_set, we_clr, we_dir;
    gpio_reg_e sel;

    // decode the write strobes from the address
    always_comb begin
        sel     = gpio_reg_e'(bus_addr);
        we_load = bus_wr_en && (sel == REG_LEVEL);
        we_set  = bus_wr_en && (sel == REG_SET);
        we_clr  = bus_wr_en && (sel == REG_CLR);
        we_dir  = bus_wr_en && (sel == REG_DIR);
    end

    gpio_bitmap #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_wmap (
        .din(bus_wr_data), .dout(wline));

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_s));

    gpio_out_reg #(.WIDTH(WIDTH), .HAS_CLR(HAS_CLR)) u_out (
        .clk(clk), .rst_n(rst_n), .we_load(we_load), .we_set(we_set),
        .we_clr(we_clr), .wline(wline), .q(line_out));

    gpio_dir_reg #(.WIDTH(WIDTH), .DIR_IS_INPUT(DIR_IS_INPUT)) u_dir (
        .clk(clk), .rst_n(rst_n), .we(we_dir), .wline(wline),
        .q(dir_q), .oe(line_oe));

    // select the read word in line order
    always_comb begin
        unique case (sel)
            REG_LEVEL: rd_line = pin_s;
            REG_SET:   rd_line = (line_out & line_oe) | (pin_s & ~line_oe);
            REG_CLR:   rd_line = '0;
            REG_DIR:   rd_line = dir_q;
            default:   rd_line = '0;
        endcase
    end

    gpio_bitmap #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_rmap (
        .din(rd_line), .dout(rd_bus));

    // capture the read word on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rd_data <= '0;
        else if (bus_rd_en) bus_rd_data <= rd_bus;
    end

    a_r10_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rd_data));

    a_r3_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && sel == REG_CLR) |=> (bus_rd_data == '0));
endmodule

// File: tb/mmio_gpio_ctrl_tb.sv
`timescale 1ns/1ps
module mmio_gpio_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic [2:0]  wr_en = '0;
    logic [2:0]  rd_en = '0;
    logic [31:0] wdata = '0;
    logic [31:0] pin_a = '0, pin_b = '0;
    logic [7:0]  pin_m = '0;
    logic [31:0] rd_a, rd_b, out_a, out_b, oe_a, oe_b;
    logic [7:0]  rd_m, out_m, oe_m;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mmio_gpio_ctrl #(.WIDTH(32), .HAS_CLR(1), .DIR_IS_INPUT(0), .MIRROR(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en[0]),
        .bus_wr_data(wdata), .bus_rd_en(rd_en[0]), .bus_rd_data(rd_a),
        .pin_in(pin_a), .line_out(out_a), .line_oe(oe_a));

    mmio_gpio_ctrl #(.WIDTH(32), .HAS_CLR(0), .DIR_IS_INPUT(0), .MIRROR(0)) u_noclr (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en[1]),
        .bus_wr_data(wdata), .bus_rd_en(rd_en[1]), .bus_rd_data(rd_b),
        .pin_in(pin_b), .line_out(out_b), .line_oe(oe_b));

    mmio_gpio_ctrl #(.WIDTH(8), .HAS_CLR(1), .DIR_IS_INPUT(1), .MIRROR(1)) u_mir (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en[2]),
        .bus_wr_data(wdata[7:0]), .bus_rd_en(rd_en[2]), .bus_rd_data(rd_m),
        .pin_in(pin_m), .line_out(out_m), .line_oe(oe_m));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int s, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en[s] = 1'b1;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic bus_read(input int s, input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en[s] = 1'b1;
        @(negedge clk);
        rd_en = '0;
        case (s)
            0: d = rd_a;
            1: d = rd_b;
            default: d = {24'h0, rd_m};
        endcase
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 line_out", out_a, 0);
        check("R1 line_oe", oe_a, 0);
        check("R1 rd_data", rd_a, 0);
        check("R1 mirrored oe", oe_m, 0);
        bus_read(0, 2'd3, v); check("R6 dir reset output-select", v, 32'h0);
        bus_read(2, 2'd3, v); check("R6 dir reset input-select", v, 32'hFF);
    endtask

    task automatic t_set_clr;
        logic [31:0] v;
        bus_write(0, 2'd1, 32'h0000_00F0); check("R2 set first", out_a, 32'h0000_00F0);
        bus_write(0, 2'd1, 32'h0000_0F00); check("R2 set keeps zeros", out_a, 32'h0000_0FF0);
        bus_write(0, 2'd2, 32'h0000_0030); check("R3 clear ones", out_a, 32'h0000_0FC0);
        bus_write(0, 2'd2, 32'h0000_0000); check("R3 clear zero no effect", out_a, 32'h0000_0FC0);
        bus_read(0, 2'd2, v); check("R3 clear reads zero", v, 0);
        bus_write(0, 2'd0, 32'hA5A5_5A5A); check("R5 level load", out_a, 32'hA5A5_5A5A);
    endtask

    task automatic t_dir_pins;
        logic [31:0] v;
        bus_write(0, 2'd3, 32'h0000_FFFF); check("R6 output-select oe", oe_a, 32'h0000_FFFF);
        bus_read(0, 2'd3, v); check("R6 dir readback", v, 32'h0000_FFFF);
        @(negedge clk); pin_a = 32'h1234_5678;
        bus_read(0, 2'd0, v); check("R7 one edge still old", v, 32'h0);
        @(negedge clk); pin_a = 32'h8765_4321;
        @(negedge clk);
        bus_read(0, 2'd0, v); check("R7 third edge new", v, 32'h8765_4321);
        bus_read(0, 2'd1, v); check("R8 set readback mix", v, 32'h8765_5A5A);
        @(negedge clk); pin_a = 32'h0;
        repeat (4) @(negedge clk);
        check("R10 rd_data holds", rd_a, 32'h8765_5A5A);
    endtask

    task automatic t_noclr;
        bus_write(1, 2'd1, 32'h0000_00FF); check("R4 set loads", out_b, 32'h0000_00FF);
        bus_write(1, 2'd1, 32'h0000_000F); check("R4 zeros drive low", out_b, 32'h0000_000F);
        bus_write(1, 2'd2, 32'h0000_000F); check("R4 clear ignored", out_b, 32'h0000_000F);
    endtask

    task automatic t_mirror;
        logic [31:0] v;
        bus_write(2, 2'd3, 32'h0000_00FE); check("R9 R6 mirrored input-select oe", oe_m, 8'h80);
        bus_write(2, 2'd1, 32'h0000_0001); check("R9 set bit0 is line7", out_m, 8'h80);
        @(negedge clk); pin_m = 8'h01;
        repeat (2) @(negedge clk);
        bus_read(2, 2'd0, v); check("R9 line0 pin at bit7", v, 32'h80);
        bus_read(2, 2'd1, v); check("R9 R8 mirrored set readback", v, 32'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_set_clr;
        t_dir_pins;
        t_noclr;
        t_mirror;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule